// File: doc/BRIEF.md
# Packet-to-Burst Segmenter

This block turns packets arriving on several input ports into one stream of 64-bit words. Each output word is marked as either a control word or a data word. Each input port carries 8-byte data words, a start flag, an end flag, a count of the valid bytes in the final word, and a 16-bit logical channel number. The segmenter cuts each packet into bursts. A burst is limited to a configurable number of 64-byte units. Every burst opens with a control word that carries the channel and whether the burst starts a packet.

The close of a burst is reported by the next control word. When a packet ended in that burst, this word carries an end flag and the valid-byte count. If another burst is ready, this information rides in that burst's opening word. If no burst is ready, a standalone closing word is sent. Bursts shorter than the minimum length are followed by idle control words. These idles keep burst delimiters at least a minimum spacing apart.

A static mode input selects one of two behaviours. In whole-packet mode, a started packet holds the output until it ends. In segment mode, the ports are served round-robin at every burst boundary, so packets on different channels interleave.

Top module: `burst_segmenter`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is low and every `in_ready` bit is low.
- R2: A burst opens with a control word that has bit 63 (burst-open) set. Bit 62 is set if the burst's first word has `in_sop` set. Bits 57:42 carry that port's channel. The burst's data words follow with `out_ctrl` low. Each data word appears unchanged one clock after it is accepted.
- R3: A burst holds at most MAX_UNITS*8 data words. A longer packet continues in further bursts, whose opening words have bit 62 clear. A packet of exactly the maximum length fits in one burst.
- R4: A burst with n data words, where n is below MIN_WORDS, is followed by MIN_WORDS-n idle control words. Idle words are all zeros.
- R5: When a burst ends a packet, the next non-idle control word has bit 61 (end) set. Its bits 60:58 give the valid bytes in the last word: 0 means 8 bytes, and 1 to 7 mean that many bytes. A burst cut at the maximum length reports bit 61 clear.
- R6: If another burst is ready when a burst has closed, the end information rides in that burst's opening word. Otherwise a standalone closing word is sent, with bit 63 clear, bit 61 set and the byte count.
- R7: `in_ready` is raised for at most one port, and only while data words are being passed. A data word appears on the output exactly when an input word was accepted at the previous edge.
- R8: In whole-packet mode (`cfg_segment` low), once a port has started a packet, no other port opens a burst until that packet has ended.
- R9: In segment mode (`cfg_segment` high), after a burst from port p the next burst goes to the first requesting port after p in index order, wrapping around. After reset, port 0 has the highest priority.
- R10: With no input requesting and no end report pending, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_segment | input | 1 | 1 = segment (interleaved) mode, 0 = whole-packet mode |
| in_valid | input | NUM_PORTS | Per-port word valid |
| in_ready | output | NUM_PORTS | Per-port word accepted at this edge when valid |
| in_sop | input | NUM_PORTS | Per-port first word of packet |
| in_eop | input | NUM_PORTS | Per-port last word of packet |
| in_nbytes | input | NUM_PORTS*3 | Per-port valid bytes in last word (0 = 8) |
| in_chan | input | NUM_PORTS*16 | Per-port logical channel |
| in_data | input | NUM_PORTS*64 | Per-port data word |
| out_valid | output | 1 | Output word present |
| out_ctrl | output | 1 | 1 = control word, 0 = data word |
| out_word | output | 64 | Output word |

## Verification
Every output is registered. A data word shows up one edge after its acceptance. A control or idle word shows up one edge after the cycle in which `in_ready` was low for every port. The bench drives inputs and samples outputs on falling edges, and it records acceptances on rising edges, so each output word is compared in the half-cycle after the edge that produced it. The scoreboard queues the exact expected word sequence for each scenario before the stimulus starts. It pops one entry for every valid output word, so any lost, extra or reordered word is detected, whatever its latency. Each scenario also waits several idle cycles after its queue is empty, to catch trailing output.

// File: rtl/seg_pkg.sv
// seg_pkg: shared widths, control-word bit positions and the state type of
// the burst segmenter. Assumes 64-bit words and 16-bit channel numbers.
package seg_pkg;

    localparam int WORD_W  = 64;
    localparam int CHAN_W  = 16;
    localparam int NBYTE_W = 3;

    // Control-word bit positions decoded downstream.
    localparam int CW_OPEN  = 63;
    localparam int CW_SOP   = 62;
    localparam int CW_EOP   = 61;
    localparam int CW_NB_LO = 58;
    localparam int CW_CH_LO = 42;

    typedef enum logic [1:0] {
        ST_ARB  = 2'd0,
        ST_DATA = 2'd1,
        ST_PAD  = 2'd2
    } seg_state_e;

    typedef struct packed {
        logic                open;
        logic                sop;
        logic                eop;
        logic [NBYTE_W-1:0]  nbytes;
        logic [CHAN_W-1:0]   chan;
    } ctrl_fields_t;

endpackage

// File: rtl/seg_rr_arbiter.sv
// seg_rr_arbiter: round-robin choice among requesting ports. The search
// starts one past the last committed winner. Assumes commit is asserted only
// in a cycle where grant_any is high.
module seg_rr_arbiter #(
    parameter int NP = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NP-1:0]                  req,
    input  logic                           commit,
    output logic [(NP > 1 ? $clog2(NP) : 1)-1:0] grant_idx,
    output logic                           grant_any
);
    localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1;

    logic [IDX_W-1:0] last_q;

    // Pick the first requester after the last winner, wrapping around.
    always_comb begin
        grant_any = 1'b0;
        grant_idx = '0;
        for (int k = 1; k <= NP; k++) begin
            int cand;
            cand = (int'(last_q) + k) % NP;
            if (!grant_any && req[cand]) begin
                grant_any = 1'b1;
                grant_idx = IDX_W'(cand);
            end
        end
    end

    // Remember the committed winner; reset makes port 0 the first choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(NP - 1);
        end else if (commit) begin
            last_q <= grant_idx;
        end
    end

endmodule

// File: rtl/seg_port_mux.sv
// seg_port_mux: selects the head-of-line fields of one input port from the
// flattened port vectors. Purely combinational; assumes sel < NP.
module seg_port_mux
    import seg_pkg::*;
#(
    parameter int NP = 4
) (
    input  logic [(NP > 1 ? $clog2(NP) : 1)-1:0] sel,
    input  logic [NP-1:0]                  in_valid,
    input  logic [NP-1:0]                  in_sop,
    input  logic [NP-1:0]                  in_eop,
    input  logic [NP*NBYTE_W-1:0]          in_nbytes,
    input  logic [NP*CHAN_W-1:0]           in_chan,
    input  logic [NP*WORD_W-1:0]           in_data,
    output logic                           hd_valid,
    output logic                           hd_sop,
    output logic                           hd_eop,
    output logic [NBYTE_W-1:0]             hd_nbytes,
    output logic [CHAN_W-1:0]              hd_chan,
    output logic [WORD_W-1:0]              hd_data
);
    // Slice the selected port out of each flattened bus.
    always_comb begin
        hd_valid  = in_valid[sel];
        hd_sop    = in_sop[sel];
        hd_eop    = in_eop[sel];
        hd_nbytes = in_nbytes[int'(sel)*NBYTE_W +: NBYTE_W];
        hd_chan   = in_chan[int'(sel)*CHAN_W +: CHAN_W];
        hd_data   = in_data[int'(sel)*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/seg_ctrl_fmt.sv
// seg_ctrl_fmt: packs control fields into a 64-bit control word. Unused bits
// are zero, so an all-zero field set yields the idle word.
module seg_ctrl_fmt
    import seg_pkg::*;
(
    input  ctrl_fields_t       fields,
    output logic [WORD_W-1:0]  word
);
    // Place each field at its fixed bit position.
    always_comb begin
        word                              = '0;
        word[CW_OPEN]                     = fields.open;
        word[CW_SOP]                      = fields.sop;
        word[CW_EOP]                      = fields.eop;
        word[CW_NB_LO +: NBYTE_W]         = fields.nbytes;
        word[CW_CH_LO +: CHAN_W]          = fields.chan;
    end

endmodule

// File: rtl/burst_segmenter.sv
// burst_segmenter: cuts packets from NUM_PORTS input ports into bursts
// delimited by control words, pads short bursts with idles and reports each
// burst's end in the next control word. Assumes well-formed input packets
// (in_sop on the first word, in_eop on the last) and a static cfg_segment.
// MIN_WORDS must not exceed MAX_UNITS*8.
module burst_segmenter
    import seg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int MIN_WORDS = 4,
    parameter int MAX_UNITS = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_segment,
    input  logic [NUM_PORTS-1:0]          in_valid,
    output logic [NUM_PORTS-1:0]          in_ready,
    input  logic [NUM_PORTS-1:0]          in_sop,
    input  logic [NUM_PORTS-1:0]          in_eop,
    input  logic [NUM_PORTS*3-1:0]        in_nbytes,
    input  logic [NUM_PORTS*16-1:0]       in_chan,
    input  logic [NUM_PORTS*64-1:0]       in_data,
    output logic                          out_valid,
    output logic                          out_ctrl,
    output logic [63:0]                   out_word
);
    localparam int MAX_WORDS = MAX_UNITS * 8;
    localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);

    seg_state_e           state_q;
    logic [IDX_W-1:0]     grant_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     pad_q;
    logic                 close_pend_q;
    logic                 close_eop_q;
    logic [NBYTE_W-1:0]   close_nb_q;
    logic [NUM_PORTS-1:0] mid_pkt_q;

    logic [NUM_PORTS-1:0] eligible;
    logic [IDX_W-1:0]     arb_idx;
    logic                 arb_any;
    logic                 arb_commit;
    logic [IDX_W-1:0]     sel;
    logic                 hd_valid, hd_sop, hd_eop;
    logic [NBYTE_W-1:0]   hd_nbytes;
    logic [CHAN_W-1:0]    hd_chan;
    logic [WORD_W-1:0]    hd_data;
    ctrl_fields_t         fields;
    logic [WORD_W-1:0]    ctrl_word;
    logic                 emit_ctrl, emit_data;
    logic [CNT_W-1:0]     cnt_next;
    logic                 burst_end;
    logic                 close_due;

    // Ports allowed to open a burst: a started packet locks whole-packet mode.
    always_comb begin
        if (!cfg_segment && (|mid_pkt_q)) begin
            eligible = in_valid & mid_pkt_q;
        end else begin
            eligible = in_valid;
        end
    end

    assign arb_commit = (state_q == ST_ARB) && arb_any;
    assign sel        = (state_q == ST_DATA) ? grant_q : arb_idx;

    seg_rr_arbiter #(
        .NP (NUM_PORTS)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (eligible),
        .commit    (arb_commit),
        .grant_idx (arb_idx),
        .grant_any (arb_any)
    );

    seg_port_mux #(
        .NP (NUM_PORTS)
    ) u_mux (
        .sel       (sel),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_nbytes (in_nbytes),
        .in_chan   (in_chan),
        .in_data   (in_data),
        .hd_valid  (hd_valid),
        .hd_sop    (hd_sop),
        .hd_eop    (hd_eop),
        .hd_nbytes (hd_nbytes),
        .hd_chan   (hd_chan),
        .hd_data   (hd_data)
    );

    // Only the granted port is ready, and only while data words pass.
    always_comb begin
        in_ready = '0;
        if (state_q == ST_DATA) begin
            in_ready[grant_q] = 1'b1;
        end
    end

    assign close_due = close_pend_q && close_eop_q;
    assign cnt_next  = cnt_q + CNT_W'(1);
    assign burst_end = hd_eop || (cnt_next == CNT_W'(MAX_WORDS));
    assign emit_data = (state_q == ST_DATA) && hd_valid;

    // Choose the control fields: an open word, a standalone close or an idle.
    always_comb begin
        fields    = '0;
        emit_ctrl = 1'b0;
        case (state_q)
            ST_ARB: begin
                if (arb_any) begin
                    emit_ctrl     = 1'b1;
                    fields.open   = 1'b1;
                    fields.sop    = hd_sop;
                    fields.chan   = hd_chan;
                    fields.eop    = close_due;
                    fields.nbytes = close_due ? close_nb_q : '0;
                end else if (close_due) begin
                    emit_ctrl     = 1'b1;
                    fields.eop    = 1'b1;
                    fields.nbytes = close_nb_q;
                end
            end
            ST_PAD:  emit_ctrl = 1'b1;
            default: emit_ctrl = 1'b0;
        endcase
    end

    seg_ctrl_fmt u_fmt (
        .fields (fields),
        .word   (ctrl_word)
    );

    // Sequence arbitration, data passing and padding; track end reports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_ARB;
            grant_q      <= '0;
            cnt_q        <= '0;
            pad_q        <= '0;
            close_pend_q <= 1'b0;
            close_eop_q  <= 1'b0;
            close_nb_q   <= '0;
            mid_pkt_q    <= '0;
        end else begin
            case (state_q)
                ST_ARB: begin
                    if (arb_any) begin
                        grant_q      <= arb_idx;
                        cnt_q        <= '0;
                        close_pend_q <= 1'b0;
                        state_q      <= ST_DATA;
                    end else if (close_due) begin
                        close_pend_q <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (hd_valid) begin
                        cnt_q <= cnt_next;
                        if (burst_end) begin
                            close_pend_q       <= 1'b1;
                            close_eop_q        <= hd_eop;
                            close_nb_q         <= hd_eop ? hd_nbytes : '0;
                            mid_pkt_q[grant_q] <= !hd_eop;
                            if (cnt_next < CNT_W'(MIN_WORDS)) begin
                                pad_q   <= CNT_W'(MIN_WORDS) - cnt_next;
                                state_q <= ST_PAD;
                            end else begin
                                state_q <= ST_ARB;
                            end
                        end
                    end
                end
                ST_PAD: begin
                    pad_q <= pad_q - CNT_W'(1);
                    if (pad_q == CNT_W'(1)) begin
                        state_q <= ST_ARB;
                    end
                end
                default: state_q <= ST_ARB;
            endcase
        end
    end

    // Register the output word and its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ctrl  <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= emit_ctrl || emit_data;
            out_ctrl  <= emit_ctrl;
            out_word  <= emit_data ? hd_data : ctrl_word;
        end
    end

endmodule

// File: rtl/seg_checker.sv
// seg_checker: temporal properties of burst_segmenter, observed at its
// ports. Counters track words since the last burst-open word, so that the
// length and spacing windows need no deep history.
module seg_checker #(
    parameter int NP    = 4,
    parameter int MIN_W = 4,
    parameter int MAX_W = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] in_valid,
    input logic [NP-1:0] in_ready,
    input logic          out_valid,
    input logic          out_ctrl,
    input logic [63:0]   out_word
);
    logic [15:0] dcnt_q;
    logic [15:0] gap_q;
    logic        seen_open_q;
    logic        is_open;
    logic        is_delim;
    logic        is_idle;

    assign is_open  = out_valid && out_ctrl && out_word[63];
    assign is_delim = out_valid && out_ctrl && (out_word[63] || out_word[61]);
    assign is_idle  = out_valid && out_ctrl && !out_word[63] && !out_word[61];

    // Count data words and all words since the most recent open word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt_q      <= '0;
            gap_q       <= '0;
            seen_open_q <= 1'b0;
        end else if (is_open) begin
            dcnt_q      <= '0;
            gap_q       <= '0;
            seen_open_q <= 1'b1;
        end else if (out_valid) begin
            if (!out_ctrl && dcnt_q != 16'hFFFF) dcnt_q <= dcnt_q + 16'd1;
            if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
        end
    end

    AST_READY_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready)); // R7

    AST_ACCEPT_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (|(in_valid & in_ready)) |=> (out_valid && !out_ctrl)); // R2

    AST_DATA_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(in_valid & in_ready)) |=> !(out_valid && !out_ctrl)); // R7

    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ctrl) |-> (dcnt_q < 16'(MAX_W))); // R3

    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (is_delim && seen_open_q) |-> (gap_q >= 16'(MIN_W))); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |-> (out_word == 64'd0)); // R4

endmodule

bind burst_segmenter seg_checker #(
    .NP    (NUM_PORTS),
    .MIN_W (MIN_WORDS),
    .MAX_W (MAX_UNITS * 8)
) u_seg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ctrl  (out_ctrl),
    .out_word  (out_word)
);

// File: tb/burst_segmenter_tb_top.sv
// Scoreboard bench: each scenario queues its expected words, feeder tasks
// drive the ports, and a monitor pops and compares every output word.
module burst_segmenter_tb_top;

    localparam int NP = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_segment = 1'b0;
    logic [NP-1:0]       in_valid, in_ready, in_sop, in_eop;
    logic [NP*3-1:0]     in_nbytes;
    logic [NP*16-1:0]    in_chan;
    logic [NP*64-1:0]    in_data;
    logic                out_valid, out_ctrl;
    logic [63:0]         out_word;

    logic                bv [NP];
    logic                bs [NP];
    logic                be [NP];
    logic [2:0]          bn [NP];
    logic [15:0]         bc [NP];
    logic [63:0]         bd [NP];

    typedef struct {
        logic        c;
        logic [63:0] w;
        int          r;
    } exp_t;
    exp_t q[$];

    int   nvec = 0;
    int   nfail = 0;
    logic acc_q = 1'b0;
    bit   done = 0;

    always #2 clk = ~clk;

    // Flatten the per-port bench variables onto the design buses.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            in_valid[p]          = bv[p];
            in_sop[p]            = bs[p];
            in_eop[p]            = be[p];
            in_nbytes[p*3 +: 3]  = bn[p];
            in_chan[p*16 +: 16]  = bc[p];
            in_data[p*64 +: 64]  = bd[p];
        end
    end

    burst_segmenter #(
        .NUM_PORTS (NP),
        .MIN_WORDS (4),
        .MAX_UNITS (1)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_segment (cfg_segment),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_sop      (in_sop),
        .in_eop      (in_eop),
        .in_nbytes   (in_nbytes),
        .in_chan     (in_chan),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_ctrl    (out_ctrl),
        .out_word    (out_word)
    );

    function automatic logic [63:0] cw(bit o, bit s, bit e, logic [2:0] nb, logic [15:0] ch);
        logic [63:0] w;
        w = '0;
        w[63] = o; w[62] = s; w[61] = e;
        w[60:58] = nb; w[57:42] = ch;
        return w;
    endfunction

    function automatic logic [63:0] dword(int p, int k, int i);
        return {16'(p + 1), 16'(k), 32'(i)};
    endfunction

    task automatic push(logic c, logic [63:0] w, int r);
        exp_t e;
        e.c = c; e.w = w; e.r = r;
        q.push_back(e);
    endtask

    task automatic exp_data(int p, int k, int first, int last);
        for (int i = first; i <= last; i++) push(1'b0, dword(p, k, i), 2);
    endtask

    task automatic exp_idles(int n);
        for (int i = 0; i < n; i++) push(1'b1, 64'd0, 4);
    endtask

    // Record acceptances at the clock edge, as the design sees them.
    always @(posedge clk) acc_q <= rst_n && (|(in_valid & in_ready));

    // Monitor: compare each output word with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(in_ready) > 1) begin
                nfail++;
                $display("FAIL R7 in_ready=%b expected at most one bit", in_ready);
            end
            if (out_valid) begin
                nvec++;
                if (out_ctrl == acc_q) begin
                    nfail++;
                    $display("FAIL R7 out_ctrl=%0b expected %0b after accept=%0b",
                             out_ctrl, !acc_q, acc_q);
                end
                if (q.size() == 0) begin
                    nfail++;
                    $display("FAIL R10 ctrl=%0b word=%h expected no output", out_ctrl, out_word);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.c !== out_ctrl || e.w !== out_word) begin
                        nfail++;
                        $display("FAIL R%0d ctrl=%0b word=%h expected ctrl=%0b word=%h",
                                 e.r, out_ctrl, out_word, e.c, e.w);
                    end
                end
            end
        end
    end

    // Feed one packet on port p, holding each word until it is accepted.
    task automatic feed(int p, logic [15:0] ch, int k, int n, logic [2:0] nb);
        for (int i = 0; i < n; i++) begin
            bit ok;
            bv[p] = 1'b1; bs[p] = (i == 0); be[p] = (i == n - 1);
            bn[p] = (i == n - 1) ? nb : 3'd0; bc[p] = ch; bd[p] = dword(p, k, i);
            do begin
                ok = in_ready[p];
                @(negedge clk);
            end while (!ok);
        end
        bv[p] = 1'b0; bs[p] = 1'b0; be[p] = 1'b0;
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (q.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        nvec++;
        if (q.size() != 0) begin
            nfail++;
            $display("FAIL R2 %0d words missing, expected 0", q.size());
            q.delete();
        end
        repeat (8) @(negedge clk);
        nvec++;
        if (out_valid !== 1'b0) begin // R10 idle output
            nfail++;
            $display("FAIL R10 out_valid=%b expected 0", out_valid);
        end
    endtask

    // Reset sequence with the R1 checks on the held outputs.
    task automatic do_reset();
        rst_n = 1'b0;
        for (int p = 0; p < NP; p++) begin
            bv[p] = 0; bs[p] = 0; be[p] = 0; bn[p] = 0; bc[p] = 0; bd[p] = 0;
        end
        repeat (3) @(negedge clk);
        nvec++;
        if (out_valid !== 1'b0) begin nfail++; $display("FAIL R1 out_valid=%b expected 0", out_valid); end
        rst_n = 1'b1;
        @(negedge clk);
        nvec++;
        if (in_ready !== '0 || out_valid !== 1'b0) begin
            nfail++;
            $display("FAIL R1 in_ready=%b out_valid=%b expected 0/0", in_ready, out_valid);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

    initial begin
        do_reset();

        // R3 R5: 9-word packet splits 8+1; short tail padded, end with 8 bytes.
        push(1'b1, cw(1, 1, 0, 0, 16'h0A11), 2);
        exp_data(0, 1, 0, 7);
        push(1'b1, cw(1, 0, 0, 0, 16'h0A11), 3);
        exp_data(0, 1, 8, 8);
        exp_idles(3);
        push(1'b1, cw(0, 0, 1, 3'd0, 16'h0), 5);
        feed(0, 16'h0A11, 1, 9, 3'd0);
        drain();

        // R4 R6: 2-word packet on port 2, two idles, standalone close of 5 bytes.
        push(1'b1, cw(1, 1, 0, 0, 16'h0203), 2);
        exp_data(2, 2, 0, 1);
        exp_idles(2);
        push(1'b1, cw(0, 0, 1, 3'd5, 16'h0), 6);
        feed(2, 16'h0203, 2, 2, 3'd5);
        drain();

        // R4 R5: exactly the minimum, no idles, close with 3 bytes.
        push(1'b1, cw(1, 1, 0, 0, 16'h1FFF), 2);
        exp_data(1, 3, 0, 3);
        push(1'b1, cw(0, 0, 1, 3'd3, 16'h0), 5);
        feed(1, 16'h1FFF, 3, 4, 3'd3);
        drain();

        // R6: back-to-back packets; the end of the first rides in the next open.
        push(1'b1, cw(1, 1, 0, 0, 16'hFFFF), 2);
        exp_data(3, 4, 0, 0);
        exp_idles(3);
        push(1'b1, cw(1, 1, 1, 3'd1, 16'hFFFF), 6);
        exp_data(3, 5, 0, 3);
        push(1'b1, cw(0, 0, 1, 3'd7, 16'h0), 5);
        feed(3, 16'hFFFF, 4, 1, 3'd1);
        feed(3, 16'hFFFF, 5, 4, 3'd7);
        drain();

        // R8: whole-packet mode keeps port 0 until its end.
        do_reset();
        push(1'b1, cw(1, 1, 0, 0, 16'h0100), 2);
        exp_data(0, 6, 0, 7);
        push(1'b1, cw(1, 0, 0, 0, 16'h0100), 8);
        exp_data(0, 6, 8, 9);
        exp_idles(2);
        push(1'b1, cw(1, 1, 1, 3'd2, 16'h0101), 8);
        exp_data(1, 7, 0, 1);
        exp_idles(2);
        push(1'b1, cw(0, 0, 1, 3'd4, 16'h0), 5);
        fork
            feed(0, 16'h0100, 6, 10, 3'd2);
            feed(1, 16'h0101, 7, 2, 3'd4);
        join
        drain();

        // R9: segment mode alternates ports at burst boundaries.
        cfg_segment = 1'b1;
        do_reset();
        push(1'b1, cw(1, 1, 0, 0, 16'h0100), 9);
        exp_data(0, 6, 0, 7);
        push(1'b1, cw(1, 1, 0, 0, 16'h0101), 9);
        exp_data(1, 7, 0, 1);
        exp_idles(2);
        push(1'b1, cw(1, 0, 1, 3'd4, 16'h0100), 9);
        exp_data(0, 6, 8, 9);
        exp_idles(2);
        push(1'b1, cw(0, 0, 1, 3'd2, 16'h0), 5);
        fork
            feed(0, 16'h0100, 6, 10, 3'd2);
            feed(1, 16'h0101, 7, 2, 3'd4);
        join
        drain();

        // R3: a packet of exactly the maximum length stays in one burst.
        push(1'b1, cw(1, 1, 0, 0, 16'h0042), 3);
        exp_data(0, 8, 0, 7);
        push(1'b1, cw(0, 0, 1, 3'd6, 16'h0), 3);
        feed(0, 16'h0042, 8, 8, 3'd6);
        drain();

        report();
    end

endmodule